// File: doc/BRIEF.md
# Wide Deblocking Edge Filter

This block smooths a block boundary across sixteen independent lanes at once. Each lane carries eight unsigned 8-bit pixels that straddle the edge: four on the near side (P3, P2, P1, P0) and four on the far side (Q0, Q1, Q2, Q3). Three 8-bit thresholds are common to every lane:

- an edge limit,
- an interior limit,
- a high-variance threshold.

For each lane the block first decides whether filtering is allowed at all. It then decides whether the edge is a high-variance one. Finally it produces corrected values for the six inner pixels P2 to Q2. The outer pixels P3 and Q3 are only read.

Filtering works on signed pixels, obtained by flipping the top bit. Every arithmetic step saturates to the signed 8-bit range.

- **High-variance lanes:** only P0 and Q0 receive a short rounded correction.
- **Other enabled lanes:** a weighted correction is spread over three pixels on each side.

Results appear one clock after a valid input and are held while no new input is valid. Gathering the pixels into lanes (transposition) and memory access belong to the surrounding logic.

Top module: `edge_smoother16`

## Requirements
- R1: While reset is asserted and after its release, the following outputs are all zero until the first valid input: `out_valid`, `pix_out`, `mask_out` and `hev_out`.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. Outputs for an input accepted at clock edge n appear after edge n.
- R3: In a lane whose enable bit `mask_out[i]` is 0, the six output pixels equal the corresponding input pixels P2..Q2.
- R4: A lane is enabled (mask bit 1) only when both conditions hold; the comparisons are strictly greater-than:
  - none of |P3-P2|, |P2-P1|, |P1-P0|, |Q1-Q0|, |Q2-Q1| or |Q3-Q2| is greater than the interior limit;
  - |P0-Q0| is not greater than the edge limit.
- R5: `hev_out[i]` is 1 when max(|P1-P0|, |Q1-Q0|) is greater than the high-variance threshold, independent of the enable bit.
- R6: In a high-variance lane, the output pixels P2, P1, Q1 and Q2 equal their inputs.
- R7: The high-variance correction works on signed pixels s = x XOR 0x80.
  - Base value: f = sat(sat(sat(sat(P1-Q1)+d)+d)+d), with d = sat(Q0-P0); f is forced to 0 in disabled lanes.
  - Corrections: Q0' = sat(Q0 - (sat(f+4)>>>3)) and P0' = sat(P0 + (sat(f+3)>>>3)).
  - Each result is converted back with XOR 0x80.
- R8: A lane that is not high-variance uses the same f and w_k = sat((k*f+63)>>>7), computed at 16-bit signed width.
  - k=27: subtracted from Q0 and added to P0.
  - k=18: applied to Q1 and P1 in the same way.
  - k=9: applied to Q2 and P2 in the same way.
  - Every add and subtract saturates to the signed 8-bit range.
- R9: The block is correct at the extremes: steps between 0 and 255 saturate f and the pixel updates rather than wrapping.
- R10: In a cycle where `in_valid` is low, `pix_out`, `mask_out` and `hev_out` keep their values at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lane data and thresholds are valid this cycle |
| edge_lim | input | 8 | Limit on the step across the edge |
| inner_lim | input | 8 | Limit on steps inside each side |
| hev_thr | input | 8 | High-variance threshold |
| pix_in | input | LANES*64 | Lane i at bits [i*64 +: 64]; byte 0..7 = P3,P2,P1,P0,Q0,Q1,Q2,Q3 |
| out_valid | output | 1 | Output pixels valid |
| pix_out | output | LANES*48 | Lane i at bits [i*48 +: 48]; byte 0..5 = P2,P1,P0,Q0,Q1,Q2 |
| mask_out | output | LANES | Per-lane filter enable |
| hev_out | output | LANES | Per-lane high-variance flag |

## Verification
The block holds no state beyond its single output register, so any internal fault shows up in the very next output cycle. The possible faults are:

- an error in the enable or variance decision, which flips a mask or flag bit;
- a wrong saturation or rounding step, which shifts one pixel by a few codes;
- a broken capture, which leaves stale data.

Sweeps with pixel spreads from flat to full range push lanes across each threshold, into each correction path and into saturation. Every lane is compared against an integer model one cycle after each input.

// File: rtl/edge_smoother16.sv
module edge_smoother16 #(
  parameter int LANES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            edge_lim,
  input  logic [7:0]            inner_lim,
  input  logic [7:0]            hev_thr,
  input  logic [LANES*64-1:0]   pix_in,
  output logic                  out_valid,
  output logic [LANES*48-1:0]   pix_out,
  output logic [LANES-1:0]      mask_out,
  output logic [LANES-1:0]      hev_out
);
  localparam int IW = 64;
  localparam int OW = 48;

  function automatic logic [7:0] absdiff(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic signed [16:0] ext(input logic signed [7:0] x);
    return {{9{x[7]}}, x};
  endfunction

  function automatic logic signed [7:0] clip(input logic signed [16:0] v);
    if (v > 17'sd127) return 8'h7f;
    if (v < -17'sd128) return 8'h80;
    return v[7:0];
  endfunction

  logic [LANES*48-1:0] nxt_pix;
  logic [LANES-1:0]    nxt_mask, nxt_hev;

  for (genvar i = 0; i < LANES; i++) begin : lane
    logic [7:0] p3, p2, p1, p0, q0, q1, q2, q3;
    logic signed [7:0] sp2, sp1, sp0, sq0, sq1, sq2;
    logic signed [7:0] d, f0, f1, f2, f3, f;
    logic signed [7:0] sh4, sh3, w27, w18, w9, cq0, cp0, c1, c2;
    logic en, hv;

    assign {q3, q2, q1, q0, p0, p1, p2, p3} = pix_in[i*IW +: IW];

    assign en = !((absdiff(p3, p2) > inner_lim) || (absdiff(p2, p1) > inner_lim) ||
                  (absdiff(p1, p0) > inner_lim) || (absdiff(q1, q0) > inner_lim) ||
                  (absdiff(q2, q1) > inner_lim) || (absdiff(q3, q2) > inner_lim) ||
                  (absdiff(p0, q0) > edge_lim));
    assign hv = (absdiff(p1, p0) > hev_thr) || (absdiff(q1, q0) > hev_thr);

    assign sp2 = p2 ^ 8'h80;
    assign sp1 = p1 ^ 8'h80;
    assign sp0 = p0 ^ 8'h80;
    assign sq0 = q0 ^ 8'h80;
    assign sq1 = q1 ^ 8'h80;
    assign sq2 = q2 ^ 8'h80;

    assign d  = clip(ext(sq0) - ext(sp0));
    assign f0 = clip(ext(sp1) - ext(sq1));
    assign f1 = clip(ext(f0) + ext(d));
    assign f2 = clip(ext(f1) + ext(d));
    assign f3 = clip(ext(f2) + ext(d));
    assign f  = en ? f3 : 8'sd0;

    assign sh4 = clip(ext(f) + 17'sd4) >>> 3;
    assign sh3 = clip(ext(f) + 17'sd3) >>> 3;
    assign w27 = clip((ext(f) * 17'sd27 + 17'sd63) >>> 7);
    assign w18 = clip((ext(f) * 17'sd18 + 17'sd63) >>> 7);
    assign w9  = clip((ext(f) * 17'sd9  + 17'sd63) >>> 7);

    assign cq0 = hv ? sh4 : w27;
    assign cp0 = hv ? sh3 : w27;
    assign c1  = hv ? 8'sd0 : w18;
    assign c2  = hv ? 8'sd0 : w9;

    assign nxt_pix[i*OW +: OW] = {
      clip(ext(sq2) - ext(c2)) ^ 8'h80,
      clip(ext(sq1) - ext(c1)) ^ 8'h80,
      clip(ext(sq0) - ext(cq0)) ^ 8'h80,
      clip(ext(sp0) + ext(cp0)) ^ 8'h80,
      clip(ext(sp1) + ext(c1)) ^ 8'h80,
      clip(ext(sp2) + ext(c2)) ^ 8'h80 };
    assign nxt_mask[i] = en;
    assign nxt_hev[i]  = hv;

    assert_disabled_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (mask_out[i] || pix_out[i*OW +: OW] == $past(pix_in[i*IW+8 +: OW])));

    assert_hev_outer_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!hev_out[i] ||
        (pix_out[i*OW +: 16] == $past(pix_in[i*IW+8 +: 16]) &&
         pix_out[i*OW+32 +: 16] == $past(pix_in[i*IW+40 +: 16]))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pix_out   <= '0;
      mask_out  <= '0;
      hev_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        pix_out  <= nxt_pix;
        mask_out <= nxt_mask;
        hev_out  <= nxt_hev;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pix_out) && $stable(mask_out) && $stable(hev_out)));
endmodule

// File: tb/edge_smoother16_test.sv
module edge_smoother16_test;
  localparam int LANES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] edge_lim = 8'd0, inner_lim = 8'd0, hev_thr = 8'd0;
  logic [LANES*64-1:0] pix_in = '0;
  logic out_valid;
  logic [LANES*48-1:0] pix_out;
  logic [LANES-1:0] mask_out, hev_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_smoother16 #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .edge_lim(edge_lim), .inner_lim(inner_lim), .hev_thr(hev_thr),
    .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out),
    .mask_out(mask_out), .hev_out(hev_out));

  function automatic int cl(input int v);
    return (v > 127) ? 127 : (v < -128) ? -128 : v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // returns {mask, hev, 48-bit pixels P2..Q2}
  function automatic logic [49:0] model(input logic [63:0] ln, input int el, input int il, input int ht);
    int px[8];
    int s[8];
    int f, d, w;
    int ks[3] = '{27, 18, 9};
    bit en, hv;
    logic [47:0] o;
    for (int j = 0; j < 8; j++) begin
      px[j] = int'(ln[j*8 +: 8]);
      s[j] = px[j] - 128;
    end
    en = 1'b1;
    for (int j = 0; j < 3; j++) begin
      if (iabs(px[j] - px[j+1]) > il) en = 1'b0;
      if (iabs(px[j+4] - px[j+5]) > il) en = 1'b0;
    end
    if (iabs(px[3] - px[4]) > el) en = 1'b0;
    hv = (iabs(px[2] - px[3]) > ht) || (iabs(px[5] - px[4]) > ht);
    d = cl(s[4] - s[3]);
    f = cl(s[2] - s[5]);
    for (int r = 0; r < 3; r++) f = cl(f + d);
    if (!en) f = 0;
    if (hv) begin
      s[4] = cl(s[4] - (cl(f + 4) >>> 3));
      s[3] = cl(s[3] + (cl(f + 3) >>> 3));
    end else begin
      for (int k = 0; k < 3; k++) begin
        w = cl((ks[k] * f + 63) >>> 7);
        s[4+k] = cl(s[4+k] - w);
        s[3-k] = cl(s[3-k] + w);
      end
    end
    for (int j = 1; j < 7; j++) o[(j-1)*8 +: 8] = 8'(s[j] + 128);
    return {en, hv, o};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [LANES*64-1:0] v, input logic [7:0] el, input logic [7:0] il,
                         input logic [7:0] ht, input string force_tag);
    logic [49:0] e;
    string tag;
    pix_in = v; edge_lim = el; inner_lim = il; hev_thr = ht; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2", "out_valid", 64'(out_valid), 64'd1);
    for (int i = 0; i < LANES; i++) begin
      e = model(v[i*64 +: 64], int'(el), int'(il), int'(ht));
      check(mask_out[i] == e[49], "R4", $sformatf("mask lane %0d", i), 64'(mask_out[i]), 64'(e[49]));
      check(hev_out[i] == e[48], "R5", $sformatf("hev lane %0d", i), 64'(hev_out[i]), 64'(e[48]));
      if (force_tag != "") tag = force_tag;
      else if (!e[49]) tag = "R3";
      else if (e[48]) tag = "R7";
      else tag = "R8";
      check(pix_out[i*48 +: 48] == e[47:0], tag, $sformatf("pixels lane %0d", i),
            64'(pix_out[i*48 +: 48]), 64'(e[47:0]));
      if (e[48])
        check({pix_out[i*48+32 +: 16], pix_out[i*48 +: 16]} == {v[i*64+40 +: 16], v[i*64+8 +: 16]},
              "R6", $sformatf("outer lane %0d", i),
              64'({pix_out[i*48+32 +: 16], pix_out[i*48 +: 16]}), 64'({v[i*64+40 +: 16], v[i*64+8 +: 16]}));
    end
  endtask

  function automatic logic [63:0] mk(input int a[8]);
    logic [63:0] r;
    for (int j = 0; j < 8; j++) r[j*8 +: 8] = 8'(a[j]);
    return r;
  endfunction

  function automatic logic [63:0] rand_lane(input int spread);
    int b, x;
    logic [63:0] r;
    b = int'($urandom_range(0, 255));
    for (int j = 0; j < 8; j++) begin
      x = b + int'($urandom_range(0, 2*spread)) - spread;
      if (x < 0) x = 0;
      if (x > 255) x = 255;
      r[j*8 +: 8] = 8'(x);
    end
    return r;
  endfunction

  initial begin
    logic [LANES*64-1:0] v;
    logic [LANES*48-1:0] held;
    logic [LANES-1:0] hm, hh;
    int spreads[8] = '{0, 1, 2, 4, 8, 16, 64, 255};
    int thr[4][3] = '{'{0, 0, 0}, '{4, 8, 2}, '{20, 12, 6}, '{255, 255, 255}};

    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && pix_out == '0 && mask_out == '0 && hev_out == '0,
          "R1", "reset outputs", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && mask_out == '0 && hev_out == '0, "R1", "after release", 64'(mask_out), 64'd0);

    // all equal pixels: unchanged
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = {8{8'(i*16)}};
    run_vec(v, 8'd0, 8'd0, 8'd0, "R8");

    // extreme 0 -> 255 step, wide path and saturation
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = mk('{0, 0, 0, 0, 255, 255, 255, 255});
    run_vec(v, 8'd255, 8'd0, 8'd0, "R9");
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = mk('{255, 255, 255, 255, 0, 0, 0, 0});
    run_vec(v, 8'd255, 8'd0, 8'd0, "R9");
    // strict comparison boundary on the edge step: 255 > 254 disables
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = mk('{0, 0, 0, 0, 255, 255, 255, 255});
    run_vec(v, 8'd254, 8'd0, 8'd0, "R4");
    // interior step exactly at limit versus one above
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = mk('{100, 100, 100, 100, 110, 110, 110, 110 + (i % 2)});
    run_vec(v, 8'd10, 8'd0, 8'd5, "R4");
    // high-variance saturation both directions
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = mk('{255, 255, 255, 0, 255, 0, 0, 0});
    run_vec(v, 8'd255, 8'd255, 8'd0, "R9");
    for (int i = 0; i < LANES; i++) v[i*64 +: 64] = mk('{0, 0, 0, 255, 0, 255, 255, 255});
    run_vec(v, 8'd255, 8'd255, 8'd0, "R9");

    // R10: idle cycle keeps outputs
    held = pix_out; hm = mask_out; hh = hev_out;
    for (int i = 0; i < LANES; i++) pix_in[i*64 +: 64] = rand_lane(255);
    edge_lim = 8'd255; inner_lim = 8'd255; hev_thr = 8'd0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "idle out_valid", 64'(out_valid), 64'd0);
    check(pix_out == held && mask_out == hm && hev_out == hh, "R10", "hold pixels",
          64'(pix_out[63:0]), 64'(held[63:0]));

    // sweep over spreads and threshold sets
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 4; t++)
        for (int n = 0; n < 10; n++) begin
          for (int i = 0; i < LANES; i++) v[i*64 +: 64] = rand_lane(spreads[s]);
          run_vec(v, 8'(thr[t][0]), 8'(thr[t][1]), 8'(thr[t][2]), "");
        end
    // fully random thresholds
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < LANES; i++) v[i*64 +: 64] = rand_lane(int'($urandom_range(0, 40)));
      run_vec(v, 8'($urandom_range(0, 80)), 8'($urandom_range(0, 30)), 8'($urandom_range(0, 20)), "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule